// File: doc/BRIEF.md
# Host Bus Slave Register Interface

This block answers single-beat read and write cycles from a host processor bus. The bus has an active-low chip select, a write strobe that is low for writes and high for reads, an address bus, and a data path. The data path is split into an inbound data bus and an outbound data bus with its own output enable, so a pad ring or a bus wrapper can build the shared tri-state line. Behind the block sits a register file or FIFO set. The block reaches it through a plain port: a read strobe with an address, a returned word with a valid flag, and a write strobe with an address and a data word.

The block acts on the first clock edge at which chip select is seen low. On that same edge it classifies the cycle, latches the address into the read-address register, or the address and data into the write-address and write-data registers. It also pulses the matching strobe for one clock and pulls the acknowledge low for one clock. For a read, it then waits for the valid flag on the returned word. It latches that word onto the outbound data bus and raises the output enable. It keeps driving until chip select is released. A cycle held open with chip select low produces only one strobe and one acknowledge. The block re-arms only after it has sampled chip select high at a clock edge.

Top module: `hbs_top`

## Requirements
- R1: While the synchronous active-high reset is high, and on the first cycle after it, ack_n is 1, rd_en, wr_en and data_oe are 0, and rd_addr, wr_addr and wr_data are 0. This holds even when chip select and the write strobe are driven low during reset.
- R2: A read is recognised at an edge where the block is idle, cs_n is 0 and wr_n is 1. In the following cycle rd_en is 1 and rd_addr equals the address sampled at that edge.
- R3: A write is recognised at an edge where the block is idle and cs_n and wr_n are both 0. In the following cycle wr_en is 1, wr_addr equals the sampled address and wr_data equals the sampled data_in.
- R4: Every recognised cycle drives ack_n to 0 for exactly one clock, in the same cycle as its strobe. ack_n is 1 at all other times.
- R5: While cs_n stays 0 after a recognised cycle, no further rd_en, wr_en or ack_n pulse occurs, whatever wr_n, addr or data_in do. A new cycle can be recognised only after an edge at which cs_n was sampled 1.
- R6: During a read, the first edge with rd_valid at 1 and cs_n at 0 loads rd_data into data_out and sets data_oe to 1 from the next cycle. data_out then holds that word, ignoring later rd_data, until the edge where cs_n is sampled 1; after that edge data_oe is 0.
- R7: data_oe stays 0 during write cycles and while idle, even when rd_valid is 1. rd_valid at the recognising edge of a read is ignored.
- R8: The read-address register changes only on a recognised read. The write-address and write-data registers change only on a recognised write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Cycle direction: 0 write, 1 read |
| addr | input | AW | Host address bus |
| data_in | input | DW | Host write data |
| data_out | output | DW | Read data toward the host |
| data_oe | output | 1 | Output enable for data_out |
| ack_n | output | 1 | One-clock cycle acknowledge, active low |
| rd_en | output | 1 | Read strobe toward register file/FIFO |
| rd_addr | output | AW | Latched read address |
| rd_data | input | DW | Word returned for rd_addr |
| rd_valid | input | 1 | rd_data is valid |
| wr_en | output | 1 | Write strobe toward register file/FIFO |
| wr_addr | output | AW | Latched write address |
| wr_data | output | DW | Latched write data |

## Verification
Reads run with the valid flag arriving zero to three cycles after the strobe, and with chip select then held for zero to four further cycles. This separates a block that captures the first valid word from one that follows later return data, and a block that releases the bus on chip select from one that releases it on a timer. During held cycles, the address, the data and the write strobe are scrambled, and reads interleave with writes. These patterns expose any re-triggered strobe, any capture register loaded by the wrong cycle kind, and any output enable raised by a stray valid flag during a write or while idle. Directed cases add all-zero and all-one addresses and data, cycles that chip select holds for only one clock, and reset applied with chip select low.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    // Sequencer state: idle and armed, or holding a recognised cycle
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_RD   = 2'd1,
        HS_WR   = 2'd2
    } hs_state_e;

    // Kind of cycle seen at the current edge
    typedef enum logic [1:0] {
        CK_NONE  = 2'd0,
        CK_READ  = 2'd1,
        CK_WRITE = 2'd2
    } cyc_kind_e;

    function automatic cyc_kind_e classify(input logic cs_n, input logic wr_n,
                                           input logic armed);
        cyc_kind_e k;
        k = CK_NONE;
        if (armed && !cs_n) begin
            k = wr_n ? CK_READ : CK_WRITE;
        end
        return k;
    endfunction

endpackage

// File: rtl/hbs_decode.sv
module hbs_decode
    import hbs_pkg::*;
(
    input  logic      cs_n,
    input  logic      wr_n,
    input  hs_state_e state,
    output cyc_kind_e kind
);

    always_comb begin
        kind = classify(cs_n, wr_n, state == HS_IDLE);
    end

endmodule

// File: rtl/hbs_seq.sv
module hbs_seq
    import hbs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  cyc_kind_e kind,
    output hs_state_e state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_IDLE;
        end else begin
            case (state)
                HS_IDLE: begin
                    if (kind == CK_READ)       state <= HS_RD;
                    else if (kind == CK_WRITE) state <= HS_WR;
                end
                HS_RD, HS_WR: begin
                    // re-arm only after chip select is seen released
                    if (cs_n) state <= HS_IDLE;
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hbs_capture.sv
module hbs_capture
    import hbs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  cyc_kind_e     kind,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data_in,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          ack_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_en   <= 1'b0;
            wr_en   <= 1'b0;
            ack_n   <= 1'b1;
            rd_addr <= '0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            rd_en <= (kind == CK_READ);
            wr_en <= (kind == CK_WRITE);
            ack_n <= (kind == CK_NONE);
            if (kind == CK_READ) begin
                rd_addr <= addr;
            end
            if (kind == CK_WRITE) begin
                wr_addr <= addr;
                wr_data <= data_in;
            end
        end
    end

endmodule

// File: rtl/hbs_rdpath.sv
module hbs_rdpath
    import hbs_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  hs_state_e     state,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] data_out,
    output logic          data_oe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= '0;
            data_oe  <= 1'b0;
        end else if (cs_n) begin
            data_out <= '0;
            data_oe  <= 1'b0;
        end else if (state == HS_RD && rd_valid && !data_oe) begin
            data_out <= rd_data;
            data_oe  <= 1'b1;
        end
    end

endmodule

// File: rtl/hbs_top.sv
module hbs_top
    import hbs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic          ack_n,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    input  logic          rd_valid,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    hs_state_e state;
    cyc_kind_e kind;

    hbs_decode u_decode (
        .cs_n  (cs_n),
        .wr_n  (wr_n),
        .state (state),
        .kind  (kind)
    );

    hbs_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .kind  (kind),
        .state (state)
    );

    hbs_capture #(.AW(AW), .DW(DW)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .addr    (addr),
        .data_in (data_in),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ack_n   (ack_n)
    );

    hbs_rdpath #(.DW(DW)) u_rdpath (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .state    (state),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

endmodule

// File: rtl/hbs_chk.sv
module hbs_chk
    import hbs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          wr_n,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] data_in,
    input logic [DW-1:0] data_out,
    input logic          data_oe,
    input logic          ack_n,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input hs_state_e     state
);

    logic idle;
    assign idle = (state == HS_IDLE);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (ack_n && !rd_en && !wr_en && !data_oe &&
                        rd_addr == '0 && wr_addr == '0 && wr_data == '0));

    // R2
    rd_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && !cs_n && wr_n) |=> (rd_en && rd_addr == $past(addr)));

    // R3
    wr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && !cs_n && !wr_n) |=>
            (wr_en && wr_addr == $past(addr) && wr_data == $past(data_in)));

    // R4
    ack_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_n |=> ack_n);

    // R4
    ack_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> (rd_en || wr_en));

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) |=> !(rd_en || wr_en));

    // R5
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_en, wr_en}));

    // R6
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !data_oe);

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (data_oe && !cs_n) |=> (data_oe && $stable(data_out)));

    // R7
    oe_not_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (state == HS_WR) |-> !data_oe);

    // R8
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(idle && !cs_n && wr_n) |=> $stable(rd_addr));

    // R8
    wr_regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(idle && !cs_n && !wr_n) |=> ($stable(wr_addr) && $stable(wr_data)));

endmodule

bind hbs_top hbs_chk #(.AW(AW), .DW(DW)) u_hbs_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .data_in  (data_in),
    .data_out (data_out),
    .data_oe  (data_oe),
    .ack_n    (ack_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .state    (state)
);

// File: tb/tb_hbs_top.sv
module tb_hbs_top;

    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int CLK_P = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] data_out;
    logic          data_oe;
    logic          ack_n;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data = '0;
    logic          rd_valid = 1'b0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int n_chk  = 0;
    int n_fail = 0;

    logic [AW-1:0] e_ra = '0;
    logic [AW-1:0] e_wa = '0;
    logic [DW-1:0] e_wd = '0;

    always #(CLK_P/2) clk = ~clk;

    hbs_top #(.AW(AW), .DW(DW)) dut (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .data_in  (data_in),
        .data_out (data_out),
        .data_oe  (data_oe),
        .ack_n    (ack_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // strobes and acknowledge quiet: expected encoding {rd_en,wr_en,ack_n} = 3'b001
    task automatic quiet(input string tag);
        chk({rd_en, wr_en, ack_n} == 3'b001, tag,
            {61'd0, rd_en, wr_en, ack_n}, 64'd1);
    endtask

    // capture registers equal the bench model
    task automatic regs_kept(input string tag);
        chk(rd_addr == e_ra && wr_addr == e_wa && wr_data == e_wd, tag,
            {rd_addr, wr_addr, wr_data}, {e_ra, e_wa, e_wd});
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] v,
                           input int vw, input int hold);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b1; addr = a;
        rd_valid = 1'b1; rd_data = ~v;   // valid at the recognising edge is ignored (R7)
        @(negedge clk);
        rd_valid = 1'b0;
        e_ra = a;
        chk(rd_en == 1'b1 && wr_en == 1'b0, "R2 rd_en pulse", {rd_en, wr_en}, 2'b10);
        chk(ack_n == 1'b0, "R4 ack low with read strobe", ack_n, 0);
        regs_kept("R8 R2 capture registers after read");
        chk(data_oe == 1'b0, "R7 oe ignores early valid", data_oe, 0);
        addr = AW'($urandom);
        for (int i = 0; i < vw; i++) begin
            @(negedge clk);
            quiet("R5 no retrigger before valid");
            chk(data_oe == 1'b0, "R6 oe before valid", data_oe, 0);
            wr_n = 1'($urandom);
        end
        rd_valid = 1'b1; rd_data = v;
        @(negedge clk);
        rd_valid = 1'b0; rd_data = DW'($urandom);
        chk(data_oe == 1'b1 && data_out == v, "R6 data driven",
            {data_oe, data_out}, {1'b1, v});
        quiet("R4 single ack on read");
        for (int i = 0; i < hold; i++) begin
            rd_valid = 1'($urandom);
            wr_n = 1'($urandom);
            addr = AW'($urandom);
            @(negedge clk);
            quiet("R5 held read no retrigger");
            chk(data_oe == 1'b1 && data_out == v, "R6 data held",
                {data_oe, data_out}, {1'b1, v});
            regs_kept("R8 held read registers");
        end
        cs_n = 1'b1; wr_n = 1'b1; rd_valid = 1'b0;
        @(negedge clk);
        chk(data_oe == 1'b0, "R6 oe released", data_oe, 0);
        quiet("R5 release quiet");
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int hold);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; data_in = d;
        @(negedge clk);
        e_wa = a; e_wd = d;
        chk(wr_en == 1'b1 && rd_en == 1'b0, "R3 wr_en pulse", {rd_en, wr_en}, 2'b01);
        chk(ack_n == 1'b0, "R4 ack low with write strobe", ack_n, 0);
        regs_kept("R3 R8 capture registers after write");
        chk(data_oe == 1'b0, "R7 oe off in write", data_oe, 0);
        for (int i = 0; i < hold; i++) begin
            addr = AW'($urandom); data_in = DW'($urandom);
            wr_n = 1'($urandom); rd_valid = 1'($urandom); rd_data = DW'($urandom);
            @(negedge clk);
            quiet("R5 held write no retrigger");
            chk(data_oe == 1'b0, "R7 oe off in held write", data_oe, 0);
            regs_kept("R8 held write registers");
        end
        cs_n = 1'b1; wr_n = 1'b1; rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        chk(data_oe == 1'b0, "R7 oe off while idle", data_oe, 0);
        quiet("R4 R5 after write");
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL R5 watchdog expired act=0 exp=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // reset with chip select and write strobe driven low
        cs_n = 1'b0; wr_n = 1'b0; addr = '1; data_in = '1; rd_valid = 1'b1;
        repeat (3) @(negedge clk);
        quiet("R1 strobes off in reset");
        chk(data_oe == 1'b0, "R1 oe off in reset", data_oe, 0);
        regs_kept("R1 registers clear in reset");
        cs_n = 1'b1; wr_n = 1'b1; rd_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        quiet("R1 quiet after reset");
        regs_kept("R1 registers clear after reset");
        chk(data_oe == 1'b0, "R1 oe off after reset", data_oe, 0);

        // directed corners
        do_read('0, '1, 0, 0);
        do_write('1, '0, 0);
        do_write('0, '1, 3);
        do_read('1, '0, 3, 4);
        do_read(16'h1234, 32'hCAFE_F00D, 1, 1);

        for (int n = 0; n < 80; n++) begin
            if ($urandom % 2)
                do_read(AW'($urandom), DW'($urandom), int'($urandom % 4), int'($urandom % 5));
            else
                do_write(AW'($urandom), DW'($urandom), int'($urandom % 5));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule